// File: doc/BRIEF.md
# Periodic and Multi-Source Interrupt Generator

This block sits beside a calendar counter and produces the chip's single interrupt request. A periodic source, fed by one-cycle second and minute strobes from the counter, sets a status flag once per second or once per minute. A mode input decides how that flag reaches the interrupt output. In pulse mode a short pulse is produced, one 64 Hz period long, timed by a 64 Hz strobe. In level mode the output stays active for as long as the flag is set. The host cancels the pulse early by clearing the flag.

A parameterised number of further sources, such as alarm, watchdog, timestamp or battery events, each have a sticky flag and an enable. Each enabled source holds the output active while its flag is set. The host clears flags with a single write strobe: a 0 in a bit position clears that flag and a 1 leaves it alone. The open-drain pad is represented by an active-low drive signal. When that signal is 0, the pad pulls the line low.

Top module: `secmin_irq`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every flag and any pending or running pulse, and leaves irq_drive_n at 1.
- R2: With per_en=1 and per_minute=0, tick_sec sets flags[0] and tick_min has no effect on it. With per_minute=1, tick_min sets flags[0] and tick_sec has no effect on it. With per_en=0, neither strobe sets it.
- R3: In pulse mode (pulse_mode=1), irq_drive_n goes to 0 after the first tick_64hz strobe that comes strictly after the periodic event. A strobe in the same cycle as the event does not start the pulse. The output returns to 1 after the next tick_64hz strobe, so the pulse lasts one 64 Hz period.
- R4: In pulse mode, a write that clears flags[0] ends a running pulse in the cycle after the write. The same write also cancels a pulse that is still waiting for its start strobe.
- R5: In level mode (pulse_mode=0), irq_drive_n is 0 from the cycle after the periodic event until the cycle after flags[0] is cleared, while per_en=1. The 64 Hz strobe has no effect on the output in this mode.
- R6: Source k (src_evt[k]) sets flags[k+1] whatever the value of src_en[k]. irq_drive_n is 0 whenever any flags[k+1] and src_en[k] are both 1. A flagged source that is disabled does not drive the output.
- R7: wr_flags bit 0 maps to the periodic flag and bit k+1 maps to source k. On a cycle with wr_en=1, a 0 bit clears its flag and a 1 bit leaves it unchanged.
- R8: When a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: irq_drive_n is 0 only while a pulse is running, a level-mode periodic flag is set with per_en=1, or an enabled source flag is set. The periodic flag stays set after its pulse ends, until the host clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| per_en | input | 1 | Enables the periodic source |
| per_minute | input | 1 | 1 selects the minute strobe, 0 selects the second strobe |
| pulse_mode | input | 1 | 1 = periodic source drives a pulse, 0 = a level |
| tick_sec | input | 1 | One-cycle strobe at each new second |
| tick_min | input | 1 | One-cycle strobe at each new minute |
| tick_64hz | input | 1 | One-cycle strobe at each 64 Hz period |
| src_evt | input | NSRC | One-cycle set strobes of the other sources |
| src_en | input | NSRC | Interrupt enables of the other sources |
| wr_en | input | 1 | Flag write strobe |
| wr_flags | input | NSRC+1 | Write data: 0 clears, 1 keeps |
| flags | output | NSRC+1 | Current flags, bit 0 periodic |
| irq_drive_n | output | 1 | Active-low pad drive (0 pulls the line low) |

## Verification
The hardest case to reach from the ports is the early cut of a pulse. The host write has to land after the start strobe but before the end strobe, or between the event and the start strobe. The bench controls tick_64hz directly. It opens a pulse, waits a few idle cycles, issues the clearing write, and then sends further 64 Hz strobes to confirm that the pulse does not restart. It also sends an event in the same cycle as a 64 Hz strobe, to show that the pulse waits for the next strobe.

// File: rtl/smirq_pkg.sv
// Shared types of the second/minute interrupt generator.
package smirq_pkg;
    // How the periodic flag reaches the interrupt output.
    typedef enum logic {
        STYLE_LEVEL = 1'b0,
        STYLE_PULSE = 1'b1
    } irq_style_e;
endpackage

// File: rtl/smirq_periodic.sv
// Periodic (second/minute) flag and pulse timer.
// Assumes tick_sec, tick_min and tick_64hz are one-cycle strobes in the clk domain.
// The pulse starts at the first 64 Hz strobe strictly after the event and
// ends at the next one. A clear with no coincident event aborts it.
module smirq_periodic
    import smirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic per_en,
    input  logic per_minute,
    input  logic pulse_mode,
    input  logic tick_sec,
    input  logic tick_min,
    input  logic tick_64hz,
    input  logic clr,
    output logic flag,
    output logic pulse_on,
    output logic drive
);
    logic       evt;
    logic       flag_q;
    logic       armed_q;
    logic       pulse_q;
    irq_style_e style;

    // Select the strobe that counts as a periodic event.
    always_comb evt = per_en & (per_minute ? tick_min : tick_sec);

    // Sticky flag; a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (evt) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // Pending pulse, waiting for the next 64 Hz strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                    armed_q <= 1'b0;
        else if (evt)                  armed_q <= 1'b1;
        else if (clr)                  armed_q <= 1'b0;
        else if (tick_64hz && armed_q) armed_q <= 1'b0;
    end

    // Running pulse, one 64 Hz period long.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pulse_q <= 1'b0;
        else if (clr && !evt)          pulse_q <= 1'b0;
        else if (tick_64hz && armed_q) pulse_q <= 1'b1;
        else if (tick_64hz && pulse_q) pulse_q <= 1'b0;
    end

    // Route either the pulse or the gated flag to the request.
    always_comb begin
        style    = irq_style_e'(pulse_mode);
        flag     = flag_q;
        pulse_on = pulse_q;
        drive    = (style == STYLE_PULSE) ? pulse_q : (flag_q & per_en);
    end
endmodule

// File: rtl/smirq_srcflags.sv
// Sticky flags of the level-type interrupt sources, one per bit.
// Assumes src_evt bits are one-cycle strobes. A 0 in wr_val clears a flag on wr_en.
module smirq_srcflags #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic [NSRC-1:0] src_en,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wr_val,
    output logic [NSRC-1:0] flags,
    output logic            req
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic f_q;
        // One flag: set wins over a clearing write.
        always_ff @(posedge clk) begin
            if (!rst_n)                  f_q <= 1'b0;
            else if (src_evt[i])         f_q <= 1'b1;
            else if (wr_en && !wr_val[i]) f_q <= 1'b0;
        end
        assign flags[i] = f_q;
    end

    // Any enabled flag requests the interrupt.
    always_comb req = |(flags & src_en);
endmodule

// File: rtl/smirq_merge.sv
// Merges the periodic request and the source requests into the active-low pad drive.
// Assumes both requests are active high.
module smirq_merge (
    input  logic per_req,
    input  logic src_req,
    output logic drive_n
);
    // Open-drain model: 0 pulls the pad low.
    always_comb drive_n = ~(per_req | src_req);
endmodule

// File: rtl/secmin_irq.sv
// Top: periodic second/minute interrupt plus NSRC level sources onto one active-low output.
// Flag bit 0 is the periodic flag; bit k+1 belongs to source k.
module secmin_irq #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            per_en,
    input  logic            per_minute,
    input  logic            pulse_mode,
    input  logic            tick_sec,
    input  logic            tick_min,
    input  logic            tick_64hz,
    input  logic [NSRC-1:0] src_evt,
    input  logic [NSRC-1:0] src_en,
    input  logic            wr_en,
    input  logic [NSRC:0]   wr_flags,
    output logic [NSRC:0]   flags,
    output logic            irq_drive_n
);
    localparam int NFLAG = NSRC + 1;

    logic            per_flag;
    logic            per_pulse;
    logic            per_req;
    logic            src_req;
    logic            per_clr;
    logic [NSRC-1:0] src_flags;

    // Write decode for the periodic flag.
    always_comb per_clr = wr_en & ~wr_flags[0];

    smirq_periodic u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_en     (per_en),
        .per_minute (per_minute),
        .pulse_mode (pulse_mode),
        .tick_sec   (tick_sec),
        .tick_min   (tick_min),
        .tick_64hz  (tick_64hz),
        .clr        (per_clr),
        .flag       (per_flag),
        .pulse_on   (per_pulse),
        .drive      (per_req)
    );

    smirq_srcflags #(.NSRC(NSRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_evt (src_evt),
        .src_en  (src_en),
        .wr_en   (wr_en),
        .wr_val  (wr_flags[NFLAG-1:1]),
        .flags   (src_flags),
        .req     (src_req)
    );

    smirq_merge u_merge (
        .per_req (per_req),
        .src_req (src_req),
        .drive_n (irq_drive_n)
    );

    // Assemble the flag view.
    always_comb flags = {src_flags, per_flag};
endmodule

// File: rtl/secmin_irq_chk.sv
// Property checker for secmin_irq, attached by bind.
module secmin_irq_chk #(
    parameter int NSRC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            per_en,
    input logic            per_minute,
    input logic            pulse_mode,
    input logic            tick_sec,
    input logic            tick_min,
    input logic            tick_64hz,
    input logic [NSRC-1:0] src_en,
    input logic            wr_en,
    input logic [NSRC:0]   wr_flags,
    input logic [NSRC:0]   flags,
    input logic            irq_drive_n,
    input logic            pulse_on
);
    logic per_hit;
    logic src_any;
    always_comb per_hit = per_en && (per_minute ? tick_min : tick_sec);
    always_comb src_any = |(flags[NSRC:1] & src_en);

    // R1: reset clears flags and releases the pad
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && irq_drive_n));

    // R2: selected strobe sets the periodic flag
    a_r2_period_set: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> flags[0]);

    // R3: a pulse only starts on a 64 Hz strobe
    a_r3_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |-> $past(tick_64hz));

    // R4: a clearing write ends the pulse
    a_r4_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_flags[0] && !per_hit) |=> !pulse_on);

    // R6: an enabled, flagged source drives the pad
    a_r6_src_drives: assert property (@(posedge clk) disable iff (!rst_n)
        src_any |-> !irq_drive_n);

    // R7: writing 1 keeps a set periodic flag
    a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && wr_en && wr_flags[0]) |=> flags[0]);

    // R9: the pad is driven only for a legitimate cause
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_drive_n |-> (pulse_on || (flags[0] && per_en && !pulse_mode) || src_any));
endmodule

bind secmin_irq secmin_irq_chk #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .per_en      (per_en),
    .per_minute  (per_minute),
    .pulse_mode  (pulse_mode),
    .tick_sec    (tick_sec),
    .tick_min    (tick_min),
    .tick_64hz   (tick_64hz),
    .src_en      (src_en),
    .wr_en       (wr_en),
    .wr_flags    (wr_flags),
    .flags       (flags),
    .irq_drive_n (irq_drive_n),
    .pulse_on    (per_pulse)
);

// File: tb/secmin_irq_bench.sv
module secmin_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 4;
    localparam int N_VEC = 9;

    // Source-flag table: stimulus and expected state after one clock.
    localparam logic [3:0] V_EVT [N_VEC] = '{4'b0001, 4'b0000, 4'b0100, 4'b0000, 4'b0000,
                                            4'b1000, 4'b0010, 4'b0000, 4'b0000};
    localparam logic [3:0] V_EN  [N_VEC] = '{4'b0000, 4'b0001, 4'b0001, 4'b0100, 4'b0000,
                                            4'b1000, 4'b0000, 4'b0000, 4'b0000};
    localparam logic       V_WR  [N_VEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [4:0] V_WRF [N_VEC] = '{5'b11111, 5'b11111, 5'b11111, 5'b11101, 5'b11111,
                                            5'b10111, 5'b11011, 5'b11111, 5'b00000};
    localparam logic [4:0] V_FLG [N_VEC] = '{5'b00010, 5'b00010, 5'b01010, 5'b01000, 5'b01000,
                                            5'b10000, 5'b10100, 5'b10100, 5'b00000};
    localparam logic       V_IRQ [N_VEC] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam string      V_REQ [N_VEC] = '{"R6", "R6", "R6", "R7", "R6", "R7", "R8", "R7", "R7"};

    logic            clk = 1'b0;
    logic            rst_n;
    logic            per_en, per_minute, pulse_mode;
    logic            tick_sec, tick_min, tick_64hz;
    logic [NSRC-1:0] src_evt, src_en;
    logic            wr_en;
    logic [NSRC:0]   wr_flags;
    logic [NSRC:0]   flags;
    logic            irq_drive_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    secmin_irq #(.NSRC(NSRC)) u_secmin_irq (
        .clk(clk), .rst_n(rst_n), .per_en(per_en), .per_minute(per_minute),
        .pulse_mode(pulse_mode), .tick_sec(tick_sec), .tick_min(tick_min),
        .tick_64hz(tick_64hz), .src_evt(src_evt), .src_en(src_en), .wr_en(wr_en),
        .wr_flags(wr_flags), .flags(flags), .irq_drive_n(irq_drive_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock; strobes drop a quarter period after the edge, then checks follow.
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
        tick_sec = 0; tick_min = 0; tick_64hz = 0; src_evt = '0; wr_en = 0; wr_flags = '1;
    endtask

    task automatic clr_per();
        wr_en = 1; wr_flags = 5'b11110; step();
    endtask

    initial begin
        rst_n = 0; per_en = 0; per_minute = 0; pulse_mode = 0;
        tick_sec = 0; tick_min = 0; tick_64hz = 0;
        src_evt = '0; src_en = '0; wr_en = 0; wr_flags = '1;
        step(); step();
        check("R1 flags", int'(flags), 0);
        check("R1 irq", int'(irq_drive_n), 1);
        rst_n = 1; step();

        // Table walk over the level sources.
        for (int i = 0; i < N_VEC; i++) begin
            src_evt = V_EVT[i]; src_en = V_EN[i]; wr_en = V_WR[i]; wr_flags = V_WRF[i];
            step();
            check({V_REQ[i], " flags"}, int'(flags), int'(V_FLG[i]));
            check({V_REQ[i], " irq"}, int'(irq_drive_n), int'(V_IRQ[i]));
        end
        src_en = '0;

        // R2: strobe selection.
        per_en = 1; per_minute = 0; pulse_mode = 0;
        tick_min = 1; step();
        check("R2 min ignored in second mode", int'(flags[0]), 0);
        tick_sec = 1; step();
        check("R2 sec sets", int'(flags[0]), 1);
        clr_per();
        per_minute = 1; tick_sec = 1; step();
        check("R2 sec ignored in minute mode", int'(flags[0]), 0);
        tick_min = 1; step();
        check("R2 min sets", int'(flags[0]), 1);
        clr_per();
        per_en = 0; tick_min = 1; tick_sec = 1; step();
        check("R2 disabled", int'(flags[0]), 0);
        per_en = 1; per_minute = 0;

        // R3/R9: pulse waits for a later strobe, lasts one period, flag persists.
        pulse_mode = 1;
        tick_sec = 1; tick_64hz = 1; step();
        check("R3 coincident strobe no start", int'(irq_drive_n), 1);
        step(); step();
        check("R3 still waiting", int'(irq_drive_n), 1);
        tick_64hz = 1; step();
        check("R3 pulse running", int'(irq_drive_n), 0);
        step(); step(); step();
        check("R3 pulse held", int'(irq_drive_n), 0);
        tick_64hz = 1; step();
        check("R3 pulse ended", int'(irq_drive_n), 1);
        check("R9 flag persists", int'(flags[0]), 1);
        clr_per();
        check("R7 clear periodic", int'(flags[0]), 0);

        // R4: early clear cuts a running pulse and cancels a pending one.
        tick_sec = 1; step();
        tick_64hz = 1; step();
        check("R4 pulse on", int'(irq_drive_n), 0);
        step();
        clr_per();
        check("R4 cut short", int'(irq_drive_n), 1);
        tick_64hz = 1; step();
        check("R4 no restart", int'(irq_drive_n), 1);
        tick_sec = 1; step();
        clr_per();
        tick_64hz = 1; step();
        check("R4 pending cancelled", int'(irq_drive_n), 1);

        // R5: level mode follows the flag, ignores 64 Hz.
        pulse_mode = 0;
        tick_sec = 1; step();
        check("R5 level asserted", int'(irq_drive_n), 0);
        tick_64hz = 1; step();
        tick_64hz = 1; step();
        check("R5 64Hz no effect", int'(irq_drive_n), 0);
        clr_per();
        check("R5 released", int'(irq_drive_n), 1);

        // R8: set beats a coincident clear on the periodic flag.
        tick_sec = 1; wr_en = 1; wr_flags = 5'b11110; step();
        check("R8 periodic set wins", int'(flags[0]), 1);

        // R1: reset mid-run.
        src_evt = 4'b1111; step();
        rst_n = 0; step();
        check("R1 mid-run flags", int'(flags), 0);
        check("R1 mid-run irq", int'(irq_drive_n), 1);
        rst_n = 1; step();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule